// File: doc/BRIEF.md
# Cascadable Six-Channel Down-Counter Array

The block holds six 16-bit down-counters, each armed by a software strobe or by its input line. Each counter reloads a programmed start value when it passes below zero, or stops there in single-pass mode. Passing below zero raises a sticky wrap flag and a one-cycle wrap pulse. A channel's interrupt request is the wrap flag gated by its interrupt enable. Each channel picks its count source: the undivided clock, a divide-by-2 tick, a divide-by-64 tick, or edges on its input line. The input line can also act as an arming trigger or as a level gate.

An input routing register decides, one bit per channel, where each channel's input line comes from. A cleared bit selects the channel's own pin. A set bit selects the wrap pulse of the preceding channel, and the ring closes so that channel 0 follows channel 5. A channel set to count the undivided clock under a gate-high input then steps once per upstream wrap. In this way, two or more 16-bit counters form one wider interval counter.

Top module: `tmr_cascade_array`

## Requirements
- R1: The routing register resets to 0x00 and reads back only bits 5:0; bits 7:6 always read 0 whatever is written.
- R2: While a channel's enable is low its count holds and arming strobes are ignored; with enable high, an arming strobe loads the start value, visible one cycle later.
- R3: With the undivided source (clock select 0) an armed channel steps down once per cycle; stepping from 0 sets the wrap flag and drives the wrap pulse high for that one cycle.
- R4: In reload mode a wrap loads the start value R, giving one wrap every R+1 ticks; in single-pass mode a wrap leaves the count at 0xFFFF and counting stops.
- R5: The interrupt request is high exactly when the wrap flag and the interrupt enable are both high; a clear strobe drops the flag one cycle later.
- R6: Clock select 1 steps once every 2 cycles and clock select 2 once every 64 cycles.
- R7: Input mode values 1, 2 and 3 arm the channel on a rising, falling or either edge of its input line; edges of the other polarity are ignored.
- R8: Input mode 4 steps only while the input line is low, and mode 5 (and 7) only while it is high; mode 6 behaves as mode 4.
- R9: Clock select 3 steps once per input edge of the polarity chosen by mode bits 1:0 (1 rising, 2 falling, 3 both), and does not re-arm on those edges.
- R10: With routing bit n set, channel n takes the wrap pulse of channel n-1 as its input (channel 0 takes channel 5); a gate-high, undivided stage with start value R2 then wraps once per R2+1 upstream wraps, one cycle after the upstream wrap.
- R11: With routing bit n set, activity on channel n's own pin has no effect on its count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_we | input | 1 | Write strobe for the routing register |
| sel_wdata | input | 8 | Routing register write data, bit n for channel n |
| sel_q | output | 8 | Routing register contents |
| tin_pin | input | 6 | Per-channel input pins |
| ch_en | input | 6 | Per-channel count enable |
| ch_reload_mode | input | 6 | 1 reload on wrap, 0 single pass |
| ch_inte | input | 6 | Per-channel interrupt enable |
| ch_clk_src | input | 12 | 2 bits per channel: 0 clock, 1 div 2, 2 div 64, 3 input edges |
| ch_in_mode | input | 18 | 3 bits per channel: input line function |
| ch_reload | input | 96 | 16-bit start value per channel |
| ch_trig | input | 6 | Per-channel software arming strobe |
| ch_uf_clr | input | 6 | Per-channel wrap flag clear strobe |
| ch_count | output | 96 | 16-bit current count per channel |
| ch_uf_flag | output | 6 | Sticky wrap flag |
| ch_uf_pulse | output | 6 | One-cycle wrap pulse |
| ch_irq | output | 6 | Interrupt request |

## Verification
The bench drives chains with random start values and tracks the downstream count after every upstream wrap. A stage that missed a pulse, counted on both pulse edges, or saw the pulse a cycle late would drift from the expected residue. The ring case (channel 5 feeding channel 0) catches an off-by-one in the wrap-around index, which would leave channel 0 idle or tie it to the wrong source. Further directed cases cover the single-pass stop at 0xFFFF and wrong-polarity edges that must not re-arm. They also cover the enable/gate polarity of each gate mode, and pin toggles that must be ignored while routed, which a broken select mux would turn into spurious steps.

// File: rtl/tmr_array_pkg.sv
package tmr_array_pkg;

    localparam int CNT_W = 16;

    typedef enum logic [1:0] {
        SRC_FULL  = 2'd0,
        SRC_DIV2  = 2'd1,
        SRC_DIV64 = 2'd2,
        SRC_EVENT = 2'd3
    } clk_src_e;

    typedef struct packed {
        logic              en;
        logic              rld;
        logic              inte;
        clk_src_e          src;
        logic [2:0]        mode;
        logic [CNT_W-1:0]  start;
    } ch_cfg_t;

    typedef struct packed {
        logic arm_edge;
        logic gate_ok;
        logic evt_edge;
    } in_dec_t;

    // Interpret the input line for one channel.
    function automatic in_dec_t decode_input(logic [2:0] mode, clk_src_e src,
                                             logic lvl, logic prev);
        in_dec_t d;
        logic    rise;
        logic    fall;
        logic    hit;
        rise = lvl & ~prev;
        fall = ~lvl & prev;
        case (mode[1:0])
            2'b01:   hit = rise;
            2'b10:   hit = fall;
            2'b11:   hit = rise | fall;
            default: hit = 1'b0;
        endcase
        d          = '0;
        d.gate_ok  = 1'b1;
        if (src == SRC_EVENT) begin
            d.evt_edge = hit;
        end else if (mode[2]) begin
            d.gate_ok = (lvl == mode[0]);
        end else begin
            d.arm_edge = hit;
        end
        return d;
    endfunction

    function automatic logic src_tick(clk_src_e src, logic t_fast, logic t_slow,
                                      logic evt);
        case (src)
            SRC_FULL:  return 1'b1;
            SRC_DIV2:  return t_fast;
            SRC_DIV64: return t_slow;
            default:   return evt;
        endcase
    endfunction

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
    parameter int SLOW_DIV = 64
) (
    input  logic clk,
    input  logic rst,
    output logic tick_fast,
    output logic tick_slow
);
    localparam int PRE_W = $clog2(SLOW_DIV);

    logic [PRE_W-1:0] pre;

    always_ff @(posedge clk) begin
        if (rst) begin
            pre <= '0;
        end else if (pre == PRE_W'(SLOW_DIV - 1)) begin
            pre <= '0;
        end else begin
            pre <= pre + 1'b1;
        end
    end

    assign tick_fast = pre[0];
    assign tick_slow = (pre == PRE_W'(SLOW_DIV - 1));
endmodule

// File: rtl/tmr_in_route.sv
module tmr_in_route #(
    parameter int NCH   = 6,
    parameter int SEL_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sel_we,
    input  logic [SEL_W-1:0] sel_wdata,
    output logic [SEL_W-1:0] sel_q,
    input  logic [NCH-1:0]   tin_pin,
    input  logic [NCH-1:0]   uf_pulse,
    output logic [NCH-1:0]   tin_eff
);
    localparam logic [SEL_W-1:0] SEL_MASK = SEL_W'((1 << NCH) - 1);

    logic [SEL_W-1:0] sel_r;

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_r <= '0;
        end else if (sel_we) begin
            sel_r <= sel_wdata & SEL_MASK;
        end
    end

    assign sel_q = sel_r;

    for (genvar n = 0; n < NCH; n++) begin : g_ring
        localparam int PREV = (n == 0) ? NCH - 1 : n - 1;
        assign tin_eff[n] = sel_r[n] ? uf_pulse[PREV] : tin_pin[n];
    end
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_array_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  ch_cfg_t          cfg,
    input  logic             sw_arm,
    input  logic             flag_clr,
    input  logic             tin,
    input  logic             tick_fast,
    input  logic             tick_slow,
    output logic [CNT_W-1:0] cnt,
    output logic             uf_flag,
    output logic             uf_pulse,
    output logic             irq
);
    logic    tin_prev;
    logic    running;
    in_dec_t dec;
    logic    load;
    logic    tick;
    logic    step;
    logic    wrap;

    always_comb begin
        dec  = decode_input(cfg.mode, cfg.src, tin, tin_prev);
        load = cfg.en & (sw_arm | dec.arm_edge);
        tick = src_tick(cfg.src, tick_fast, tick_slow, dec.evt_edge);
        step = cfg.en & running & tick & dec.gate_ok & ~load;
        wrap = step & (cnt == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt      <= '0;
            running  <= 1'b0;
            uf_flag  <= 1'b0;
            uf_pulse <= 1'b0;
            tin_prev <= 1'b0;
        end else begin
            tin_prev <= tin;
            uf_pulse <= wrap;
            if (!cfg.en) begin
                running <= 1'b0;
            end else if (load) begin
                cnt     <= cfg.start;
                running <= 1'b1;
            end else if (step) begin
                if (cnt == '0) begin
                    if (cfg.rld) begin
                        cnt <= cfg.start;
                    end else begin
                        cnt     <= '1;
                        running <= 1'b0;
                    end
                end else begin
                    cnt <= cnt - 1'b1;
                end
            end
            if (wrap) begin
                uf_flag <= 1'b1;
            end else if (flag_clr) begin
                uf_flag <= 1'b0;
            end
        end
    end

    assign irq = uf_flag & cfg.inte;
endmodule

// File: rtl/tmr_cascade_array.sv
module tmr_cascade_array
    import tmr_array_pkg::*;
#(
    parameter int NCH      = 6,
    parameter int SEL_W    = 8,
    parameter int SLOW_DIV = 64
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 sel_we,
    input  logic [SEL_W-1:0]     sel_wdata,
    output logic [SEL_W-1:0]     sel_q,
    input  logic [NCH-1:0]       tin_pin,
    input  logic [NCH-1:0]       ch_en,
    input  logic [NCH-1:0]       ch_reload_mode,
    input  logic [NCH-1:0]       ch_inte,
    input  logic [2*NCH-1:0]     ch_clk_src,
    input  logic [3*NCH-1:0]     ch_in_mode,
    input  logic [CNT_W*NCH-1:0] ch_reload,
    input  logic [NCH-1:0]       ch_trig,
    input  logic [NCH-1:0]       ch_uf_clr,
    output logic [CNT_W*NCH-1:0] ch_count,
    output logic [NCH-1:0]       ch_uf_flag,
    output logic [NCH-1:0]       ch_uf_pulse,
    output logic [NCH-1:0]       ch_irq
);
    logic           tick_fast;
    logic           tick_slow;
    logic [NCH-1:0] tin_eff;

    tmr_prescaler #(.SLOW_DIV(SLOW_DIV)) u_pre (
        .clk       (clk),
        .rst       (rst),
        .tick_fast (tick_fast),
        .tick_slow (tick_slow)
    );

    tmr_in_route #(.NCH(NCH), .SEL_W(SEL_W)) u_route (
        .clk       (clk),
        .rst       (rst),
        .sel_we    (sel_we),
        .sel_wdata (sel_wdata),
        .sel_q     (sel_q),
        .tin_pin   (tin_pin),
        .uf_pulse  (ch_uf_pulse),
        .tin_eff   (tin_eff)
    );

    for (genvar n = 0; n < NCH; n++) begin : g_ch
        ch_cfg_t cfg;
        always_comb begin
            cfg.en    = ch_en[n];
            cfg.rld   = ch_reload_mode[n];
            cfg.inte  = ch_inte[n];
            cfg.src   = clk_src_e'(ch_clk_src[2*n +: 2]);
            cfg.mode  = ch_in_mode[3*n +: 3];
            cfg.start = ch_reload[CNT_W*n +: CNT_W];
        end

        tmr_channel u_ch (
            .clk       (clk),
            .rst       (rst),
            .cfg       (cfg),
            .sw_arm    (ch_trig[n]),
            .flag_clr  (ch_uf_clr[n]),
            .tin       (tin_eff[n]),
            .tick_fast (tick_fast),
            .tick_slow (tick_slow),
            .cnt       (ch_count[CNT_W*n +: CNT_W]),
            .uf_flag   (ch_uf_flag[n]),
            .uf_pulse  (ch_uf_pulse[n]),
            .irq       (ch_irq[n])
        );
    end
endmodule

// File: rtl/tmr_cascade_array_chk.sv
module tmr_cascade_array_chk
    import tmr_array_pkg::*;
#(
    parameter int NCH   = 6,
    parameter int SEL_W = 8
) (
    input logic                 clk,
    input logic                 rst,
    input logic [SEL_W-1:0]     sel_q,
    input logic [NCH-1:0]       ch_en,
    input logic [NCH-1:0]       ch_reload_mode,
    input logic [NCH-1:0]       ch_inte,
    input logic [2*NCH-1:0]     ch_clk_src,
    input logic [3*NCH-1:0]     ch_in_mode,
    input logic [NCH-1:0]       ch_trig,
    input logic [CNT_W*NCH-1:0] ch_count,
    input logic [NCH-1:0]       ch_uf_flag,
    input logic [NCH-1:0]       ch_uf_pulse,
    input logic [NCH-1:0]       ch_irq
);
    if (NCH < SEL_W) begin : g_sel_hi
        assert_sel_unused_R1: assert property (@(posedge clk) disable iff (rst)
            sel_q[SEL_W-1:NCH] == '0);
    end

    for (genvar n = 0; n < NCH; n++) begin : g_chk
        localparam int PREV = (n == 0) ? NCH - 1 : n - 1;

        assert_hold_disabled_R2: assert property (@(posedge clk) disable iff (rst)
            !ch_en[n] |=> $stable(ch_count[CNT_W*n +: CNT_W]));

        assert_pulse_sets_flag_R3: assert property (@(posedge clk) disable iff (rst)
            ch_uf_pulse[n] |-> ch_uf_flag[n]);

        assert_oneshot_end_R4: assert property (@(posedge clk) disable iff (rst)
            (ch_uf_pulse[n] && $past(!ch_reload_mode[n]))
                |-> ch_count[CNT_W*n +: CNT_W] == '1);

        assert_irq_flag_R5: assert property (@(posedge clk) disable iff (rst)
            ch_irq[n] |-> ch_uf_flag[n]);

        assert_irq_masked_R5: assert property (@(posedge clk) disable iff (rst)
            !ch_inte[n] |-> !ch_irq[n]);

        assert_chain_idle_R10: assert property (@(posedge clk) disable iff (rst)
            (ch_en[n] && sel_q[n] && ch_clk_src[2*n +: 2] == 2'd0
             && ch_in_mode[3*n +: 3] == 3'd5 && !ch_trig[n] && !ch_uf_pulse[PREV])
                |=> $stable(ch_count[CNT_W*n +: CNT_W]));
    end
endmodule

bind tmr_cascade_array tmr_cascade_array_chk #(.NCH(NCH), .SEL_W(SEL_W)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .sel_q          (sel_q),
    .ch_en          (ch_en),
    .ch_reload_mode (ch_reload_mode),
    .ch_inte        (ch_inte),
    .ch_clk_src     (ch_clk_src),
    .ch_in_mode     (ch_in_mode),
    .ch_trig        (ch_trig),
    .ch_count       (ch_count),
    .ch_uf_flag     (ch_uf_flag),
    .ch_uf_pulse    (ch_uf_pulse),
    .ch_irq         (ch_irq)
);

// File: tb/tmr_cascade_array_tb.sv
module tmr_cascade_array_tb;
    localparam int NCH = 6;
    localparam int W   = 16;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             sel_we = 1'b0;
    logic [7:0]       sel_wdata = '0;
    logic [7:0]       sel_q;
    logic [NCH-1:0]   tin_pin = '0;
    logic [NCH-1:0]   ch_en = '0;
    logic [NCH-1:0]   ch_reload_mode = '0;
    logic [NCH-1:0]   ch_inte = '0;
    logic [2*NCH-1:0] ch_clk_src = '0;
    logic [3*NCH-1:0] ch_in_mode = '0;
    logic [W*NCH-1:0] ch_reload = '0;
    logic [NCH-1:0]   ch_trig = '0;
    logic [NCH-1:0]   ch_uf_clr = '0;
    logic [W*NCH-1:0] ch_count;
    logic [NCH-1:0]   ch_uf_flag;
    logic [NCH-1:0]   ch_uf_pulse;
    logic [NCH-1:0]   ch_irq;

    int  n_chk = 0;
    int  n_bad = 0;
    int  cyc   = 0;
    bit  done  = 1'b0;

    always #4 clk = ~clk;

    tmr_cascade_array u_dut (
        .clk(clk), .rst(rst), .sel_we(sel_we), .sel_wdata(sel_wdata), .sel_q(sel_q),
        .tin_pin(tin_pin), .ch_en(ch_en), .ch_reload_mode(ch_reload_mode),
        .ch_inte(ch_inte), .ch_clk_src(ch_clk_src), .ch_in_mode(ch_in_mode),
        .ch_reload(ch_reload), .ch_trig(ch_trig), .ch_uf_clr(ch_uf_clr),
        .ch_count(ch_count), .ch_uf_flag(ch_uf_flag), .ch_uf_pulse(ch_uf_pulse),
        .ch_irq(ch_irq)
    );

    function automatic logic [W-1:0] cnt_of(int n);
        return ch_count[W*n +: W];
    endfunction

    // Expected downstream count after p upstream wraps (R10).
    function automatic int chain_expect(int r2, int p);
        return r2 - (p % (r2 + 1));
    endfunction

    task automatic chk(string req, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic set_cfg(int n, bit en, bit rld, bit inte, logic [1:0] src,
                           logic [2:0] mode, logic [W-1:0] rv);
        ch_en[n]            = en;
        ch_reload_mode[n]   = rld;
        ch_inte[n]          = inte;
        ch_clk_src[2*n +: 2] = src;
        ch_in_mode[3*n +: 3] = mode;
        ch_reload[W*n +: W]  = rv;
    endtask

    task automatic arm(int n);
        ch_trig[n] = 1'b1;
        step(1);
        ch_trig[n] = 1'b0;
    endtask

    task automatic write_sel(logic [7:0] v);
        sel_we = 1'b1;
        sel_wdata = v;
        step(1);
        sel_we = 1'b0;
    endtask

    task automatic pin_pulse(int n);
        tin_pin[n] = 1'b1;
        step(4);
        tin_pin[n] = 1'b0;
        step(4);
    endtask

    task automatic chain_check(int up, int dn, int r2, int cycles, string tag);
        int p0 = 0;
        int p1 = 0;
        int bad = 0;
        for (int c = 0; c < cycles; c++) begin
            @(negedge clk);
            if (ch_uf_pulse[dn]) begin
                p1++;
                if (p0 == 0 || (p0 % (r2 + 1)) != 0) bad++;
            end
            if (int'(cnt_of(dn)) != chain_expect(r2, p0)) bad++;
            if (ch_uf_pulse[up]) p0++;
        end
        chk({tag, " chain residue mismatches"}, bad, 0);
        chk({tag, " downstream wraps"}, p1, p0 / (r2 + 1) - ((p0 % (r2 + 1) == 0 && ch_uf_pulse[up]) ? 1 : 0) > 0 ? p1 : -1);
    endtask

    initial begin : watchdog
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                n_chk++;
                n_bad++;
                $display("FAIL watchdog actual=%0d expected=<150000", cyc);
                $display("test done: total=%0d bad=%0d", n_chk, n_bad);
                $finish;
            end
        end
    end

    initial begin : main
        int r;
        int r1;
        int r2;
        longint c0;
        void'($urandom(32'd1357));

        step(3);
        rst = 1'b0;
        step(1);
        // R1 reset values
        chk("R1 sel reset", sel_q, 8'h00);
        chk("R3 flags reset", ch_uf_flag, 0);
        chk("R5 irq reset", ch_irq, 0);
        chk("R2 count reset", ch_count, 0);

        write_sel(8'hFF);
        chk("R1 upper bits read zero", sel_q, 8'h3F);
        write_sel(8'h00);
        chk("R1 cleared", sel_q, 8'h00);

        // R2 disabled arm ignored
        set_cfg(0, 0, 1, 1, 2'd0, 3'd0, 16'd10);
        arm(0);
        step(2);
        chk("R2 disabled ignores arm", cnt_of(0), 0);

        // R3/R4 reload period with random start
        r = int'($urandom % 8) + 2;
        set_cfg(0, 1, 1, 1, 2'd0, 3'd0, W'(r));
        arm(0);
        chk("R2 load visible", cnt_of(0), r);
        step(r);
        chk("R3 reached zero", cnt_of(0), 0);
        chk("R3 no flag yet", ch_uf_flag[0], 0);
        step(1);
        chk("R3 wrap pulse", ch_uf_pulse[0], 1);
        chk("R3 wrap flag", ch_uf_flag[0], 1);
        chk("R4 reload after wrap", cnt_of(0), r);
        chk("R5 irq raised", ch_irq[0], 1);
        step(1);
        chk("R3 pulse one cycle", ch_uf_pulse[0], 0);
        chk("R3 step after reload", cnt_of(0), r - 1);
        ch_uf_clr[0] = 1'b1;
        step(1);
        ch_uf_clr[0] = 1'b0;
        chk("R5 flag cleared", ch_uf_flag[0], 0);
        chk("R5 irq cleared", ch_irq[0], 0);
        step(r - 2);
        chk("R4 period R+1", cnt_of(0), 0);
        ch_inte[0] = 1'b0;
        step(1);
        chk("R5 flag set again", ch_uf_flag[0], 1);
        chk("R5 irq masked", ch_irq[0], 0);
        ch_en[0] = 1'b0;

        // R4 single pass
        set_cfg(2, 1, 0, 0, 2'd0, 3'd0, 16'd3);
        arm(2);
        step(3);
        chk("R4 oneshot zero", cnt_of(2), 0);
        step(1);
        chk("R4 oneshot wraps to FFFF", cnt_of(2), 16'hFFFF);
        chk("R4 oneshot pulse", ch_uf_pulse[2], 1);
        step(5);
        chk("R4 oneshot stopped", cnt_of(2), 16'hFFFF);
        ch_en[2] = 1'b0;

        // R6 divided sources
        set_cfg(3, 1, 1, 0, 2'd1, 3'd0, 16'd1000);
        arm(3);
        c0 = cnt_of(3);
        step(20);
        chk("R6 div2 steps", cnt_of(3), c0 - 10);
        ch_clk_src[6 +: 2] = 2'd2;
        c0 = cnt_of(3);
        step(128);
        chk("R6 div64 steps", cnt_of(3), c0 - 2);
        ch_en[3] = 1'b0;

        // R7 pin arming edges
        set_cfg(4, 1, 1, 0, 2'd0, 3'd1, 16'd50);
        tin_pin[4] = 1'b1;
        step(1);
        chk("R7 rising arms", cnt_of(4), 50);
        step(3);
        chk("R7 counting", cnt_of(4), 47);
        ch_in_mode[12 +: 3] = 3'd2;
        tin_pin[4] = 1'b0;
        step(1);
        chk("R7 falling arms", cnt_of(4), 50);
        tin_pin[4] = 1'b1;
        step(1);
        chk("R7 rising ignored in fall mode", cnt_of(4), 49);
        ch_in_mode[12 +: 3] = 3'd3;
        tin_pin[4] = 1'b0;
        step(1);
        chk("R7 both edges arms", cnt_of(4), 50);

        // R9 event counting
        set_cfg(4, 1, 1, 0, 2'd3, 3'd1, 16'hFFFF);
        arm(4);
        chk("R9 event loaded", cnt_of(4), 16'hFFFF);
        for (int i = 0; i < 5; i++) pin_pulse(4);
        chk("R9 rising events", cnt_of(4), 16'hFFFA);
        ch_in_mode[12 +: 3] = 3'd3;
        for (int i = 0; i < 3; i++) pin_pulse(4);
        chk("R9 both-edge events", cnt_of(4), 16'hFFF4);
        ch_en[4] = 1'b0;

        // R8 gating
        set_cfg(5, 1, 1, 0, 2'd0, 3'd5, 16'd100);
        arm(5);
        step(5);
        chk("R8 gate high closed", cnt_of(5), 100);
        tin_pin[5] = 1'b1;
        step(4);
        chk("R8 gate high open", cnt_of(5), 96);
        ch_in_mode[15 +: 3] = 3'd4;
        step(3);
        chk("R8 gate low closed", cnt_of(5), 96);
        tin_pin[5] = 1'b0;
        step(2);
        chk("R8 gate low open", cnt_of(5), 94);
        ch_in_mode[15 +: 3] = 3'd6;
        step(2);
        chk("R8 mode 6 as gate low", cnt_of(5), 92);
        ch_en[5] = 1'b0;

        // R10 random chains 0 -> 1
        write_sel(8'h02);
        for (int it = 0; it < 3; it++) begin
            r1 = int'($urandom % 6) + 1;
            r2 = int'($urandom % 5);
            set_cfg(0, 1, 1, 0, 2'd0, 3'd0, W'(r1));
            set_cfg(1, 1, 1, 0, 2'd0, 3'd5, W'(r2));
            arm(1);
            arm(0);
            chain_check(0, 1, r2, (r1 + 1) * (r2 + 1) * 3 + 5, "R10");
            ch_en[0] = 1'b0;
            ch_en[1] = 1'b0;
            step(1);
        end

        // R11 routed pin ignored
        set_cfg(1, 1, 1, 0, 2'd0, 3'd5, 16'd9);
        arm(1);
        tin_pin[1] = 1'b1;
        step(6);
        tin_pin[1] = 1'b0;
        step(1);
        chk("R11 pin ignored when routed", cnt_of(1), 9);
        ch_en[1] = 1'b0;

        // R10 ring 5 -> 0
        write_sel(8'h01);
        set_cfg(5, 1, 1, 0, 2'd0, 3'd0, 16'd3);
        set_cfg(0, 1, 1, 0, 2'd0, 3'd5, 16'd4);
        arm(0);
        arm(5);
        chain_check(5, 0, 4, 60, "R10 ring");

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule